// File: doc/BRIEF.md
# Flash Reset and Ready Sequencer

This block handles the active-low hardware reset pin of a parallel NOR-style flash device. It samples the synchronised reset pin every clock and counts how long it has been low. Only a low level that lasts a minimum number of cycles counts as a reset. A shorter dip is filtered out and leaves the device as it was. When a reset qualifies, the block does three things: it pulses an abort to the embedded program/erase engine if that engine is busy, it pulses a clear that returns the command state machine to read-array mode, and it shuts the command gate and the data output drivers for as long as the pin stays low.

After the pin is released, the block follows one of two recovery paths. The path depends on whether a program or erase was running when the reset qualified.
- **Busy path.** The ready/busy output (1 = ready) is held at 0 for a long internal interval, counted from the qualifying edge. Commands and reads resume when that interval ends.
- **Idle path.** Ready/busy stays at 1. A shorter internal interval must finish first, and then reads are held off for a fixed number of cycles.

The output drivers are also gated by output-enable and chip-enable, both active low. Outside reset handling, ready/busy simply follows the engine's busy flag.

The controller is a six-state machine:
- ST_IDLE → ST_QUALIFY on a low pin.
- ST_QUALIFY → ST_IDLE on a high pin, or → ST_IN_RESET when the width is met.
- ST_IN_RESET → ST_RECOVER_BUSY, ST_IDLE, ST_RECOVER_IDLE or ST_READ_HOLDOFF on release, chosen by the captured busy flag and the time left on the interval.
- ST_RECOVER_BUSY → ST_IDLE when the interval expires.
- ST_RECOVER_IDLE → ST_READ_HOLDOFF when the short interval expires.
- ST_READ_HOLDOFF → ST_IDLE when the hold-off expires.
- Any of the three recovery states → ST_IN_RESET when a new qualified reset arrives.

Timing comes from one shared down-counter and a separate pulse-width counter.

Top module: `flash_rst_seq`

## Requirements
- R1: The reset pin counts as a reset only after it has been sampled low on MIN_PULSE consecutive rising edges. A shorter low pulse causes no abort pulse and no clear pulse, and commands are accepted again as soon as the pin reads high.
- R2: `algo_abort` is a one-cycle active-high pulse in the cycle after the qualifying edge. It is emitted only if `algo_busy` was 1 at that edge.
- R3: Every qualified reset produces a one-cycle active-high `cmd_to_read` pulse, in the same cycle as any abort pulse.
- R4: While `rst_pin_n` is 0, `cmd_accept` and `dout_en` are both 0.
- R5: If `algo_busy` was 1 at the qualifying edge, `ready_busy` is 0 for the T_BUSY cycles that follow that edge and is 1 after them. With the pin high by then, commands and reads resume in the same cycle that `ready_busy` returns to 1.
- R6: If `algo_busy` was 0 at the qualifying edge, `ready_busy` stays 1 throughout. If the pin is released after the T_IDLE interval has run out, commands and reads resume T_HOLD cycles after the first edge that samples the pin high.
- R7: On the idle path, if the pin is released before T_IDLE cycles have passed since the qualifying edge, commands and reads resume T_IDLE + T_HOLD cycles after that edge.
- R8: A reset that qualifies during busy recovery restarts the T_BUSY interval from the new qualifying edge, and `ready_busy` stays 0 throughout. A filtered glitch during read hold-off leaves the resume time unchanged and causes no pulse.
- R9: `dout_en` is 1 only when `oe_n` = 0, `ce_n` = 0 and `cmd_accept` = 1. If `oe_n` or `ce_n` is 1, the drivers are high impedance.
- R10: After `rst_n` is released, the block is idle: `cmd_accept` = 1, no pulses, and `ready_busy` = NOT `algo_busy`.
- R11: Outside reset handling, `ready_busy` follows the inverse of `algo_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| rst_pin_n | input | 1 | Synchronised hardware reset pin, active low |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| algo_busy | input | 1 | Embedded program/erase engine is running |
| algo_abort | output | 1 | One-cycle abort strobe to the engine |
| cmd_to_read | output | 1 | One-cycle strobe returning the command state machine to read-array |
| cmd_accept | output | 1 | Read/write commands may be accepted |
| dout_en | output | 1 | Data output drivers enabled (0 = high impedance) |
| ready_busy | output | 1 | Ready/busy level, 1 = ready, 0 = busy |

## Verification
Each reset episode is a low pulse of chosen length on the pin, with the engine either busy or idle.

- **Length just under the minimum width.** This separates filtering from qualification.
- **Short and long holds on the idle path.** These separate the case where the internal interval bounds the resume time (R7) from the case where the release edge plus hold-off bounds it (R6).
- **Short and long holds on the busy path.** These confirm that the resume time follows the interval alone (R5).
- **Second pulse during busy recovery.** This shows that the interval restarts.
- **Glitch during hold-off.** This shows that the resume time is not disturbed.

Constrained-random pulse lengths and busy flags then mix these cases against a bench function that gives the expected resume cycle.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_QUALIFY      = 3'd1,
        ST_IN_RESET     = 3'd2,
        ST_RECOVER_BUSY = 3'd3,
        ST_RECOVER_IDLE = 3'd4,
        ST_READ_HOLDOFF = 3'd5
    } frs_state_e;

    function automatic int frs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/frs_width_filter.sv
// Counts consecutive low samples of the reset pin and flags the sample
// that completes the minimum width. Saturates so the flag fires once per
// low interval.
module frs_width_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic qual_hit
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] HIT_AT  = CW'(MIN_PULSE - 1);
    localparam logic [CW-1:0] SAT_AT  = CW'(MIN_PULSE);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (pin_n) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != SAT_AT) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign qual_hit = !pin_n && (low_cnt_q == HIT_AT);

endmodule

// File: rtl/frs_interval_timer.sv
// Single loadable down-counter that stops at zero.
module frs_interval_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
    import frs_pkg::*;
#(
    parameter int T_BUSY = 24,
    parameter int T_IDLE = 8,
    parameter int T_HOLD = 8,
    parameter int TW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_n,
    input  logic          qual_hit,
    input  logic [TW-1:0] tmr,
    input  logic          algo_busy,
    input  logic          oe_n,
    input  logic          ce_n,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          algo_abort,
    output logic          cmd_to_read,
    output logic          cmd_accept,
    output logic          dout_en,
    output logic          ready_busy
);
    localparam logic [TW-1:0] LD_BUSY = TW'(T_BUSY);
    localparam logic [TW-1:0] LD_IDLE = TW'(T_IDLE);
    localparam logic [TW-1:0] LD_HOLD = TW'(T_HOLD);
    localparam logic [TW-1:0] ONE_T   = TW'(1);

    frs_state_e state_q, state_d;
    logic       busy_q;        // engine was running at qualification
    logic       qual_go;       // a fresh qualified reset this cycle
    logic       busy_now;      // busy flag to capture on qualification
    logic       abort_q, clear_q;
    logic       tmr_done;      // interval ends at this edge

    assign qual_go  = qual_hit && (state_q != ST_IN_RESET);
    assign busy_now = algo_busy || (state_q == ST_RECOVER_BUSY);
    assign tmr_done = (tmr <= ONE_T);

    // next-state and timer-load decisions
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = LD_HOLD;
        if (qual_go) begin
            state_d  = ST_IN_RESET;
            tmr_load = 1'b1;
            tmr_val  = busy_now ? LD_BUSY : LD_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!pin_n) state_d = ST_QUALIFY;
                end
                ST_QUALIFY: begin
                    if (pin_n) state_d = ST_IDLE;
                end
                ST_IN_RESET: begin
                    if (pin_n) begin
                        if (busy_q) begin
                            state_d = tmr_done ? ST_IDLE : ST_RECOVER_BUSY;
                        end else if (tmr_done) begin
                            state_d  = ST_READ_HOLDOFF;
                            tmr_load = 1'b1;
                        end else begin
                            state_d = ST_RECOVER_IDLE;
                        end
                    end
                end
                ST_RECOVER_BUSY: begin
                    if (tmr_done) state_d = ST_IDLE;
                end
                ST_RECOVER_IDLE: begin
                    if (tmr_done) begin
                        state_d  = ST_READ_HOLDOFF;
                        tmr_load = 1'b1;
                    end
                end
                ST_READ_HOLDOFF: begin
                    if (tmr_done) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (qual_go) busy_q <= busy_now;
        end
    end

    // outputs: registered strobes, combinational levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
            clear_q <= 1'b0;
        end else begin
            abort_q <= qual_go && algo_busy;
            clear_q <= qual_go;
        end
    end

    always_comb begin
        algo_abort  = abort_q;
        cmd_to_read = clear_q;
        cmd_accept  = pin_n && ((state_q == ST_IDLE) || (state_q == ST_QUALIFY));
        dout_en     = cmd_accept && !oe_n && !ce_n;
        unique case (state_q)
            ST_IDLE, ST_QUALIFY:          ready_busy = !algo_busy;
            ST_IN_RESET, ST_RECOVER_BUSY: ready_busy = !(busy_q && (tmr != '0));
            default:                      ready_busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
    parameter int MIN_PULSE = 4,
    parameter int T_BUSY    = 24,
    parameter int T_IDLE    = 8,
    parameter int T_HOLD    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin_n,
    input  logic oe_n,
    input  logic ce_n,
    input  logic algo_busy,
    output logic algo_abort,
    output logic cmd_to_read,
    output logic cmd_accept,
    output logic dout_en,
    output logic ready_busy
);
    localparam int TMAX = frs_pkg::frs_max(frs_pkg::frs_max(T_BUSY, T_IDLE), T_HOLD);
    localparam int TW   = $clog2(TMAX + 1);

    logic          qual_hit;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic [TW-1:0] tmr;

    frs_width_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (rst_pin_n),
        .qual_hit (qual_hit)
    );

    frs_interval_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr)
    );

    frs_ctrl #(
        .T_BUSY (T_BUSY),
        .T_IDLE (T_IDLE),
        .T_HOLD (T_HOLD),
        .TW     (TW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n       (rst_pin_n),
        .qual_hit    (qual_hit),
        .tmr         (tmr),
        .algo_busy   (algo_busy),
        .oe_n        (oe_n),
        .ce_n        (ce_n),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .algo_abort  (algo_abort),
        .cmd_to_read (cmd_to_read),
        .cmd_accept  (cmd_accept),
        .dout_en     (dout_en),
        .ready_busy  (ready_busy)
    );

endmodule

// File: rtl/frs_checker.sv
module frs_checker (
    input logic clk,
    input logic rst_n,
    input logic rst_pin_n,
    input logic oe_n,
    input logic ce_n,
    input logic algo_busy,
    input logic algo_abort,
    input logic cmd_to_read,
    input logic cmd_accept,
    input logic dout_en,
    input logic ready_busy
);
    a_r4_gate_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin_n |-> (!cmd_accept && !dout_en));

    a_r9_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || ce_n) |-> !dout_en);

    a_r2_abort_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        algo_abort |-> $past(algo_busy));

    a_r2_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        algo_abort |=> !algo_abort);

    a_r3_clear_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
        algo_abort |-> cmd_to_read);

    a_r1_clear_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_to_read |-> $past(!rst_pin_n));

    a_r5_blocked_while_recovering: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_busy && !algo_busy) |-> !cmd_accept);

endmodule

bind flash_rst_seq frs_checker u_frs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pin_n   (rst_pin_n),
    .oe_n        (oe_n),
    .ce_n        (ce_n),
    .algo_busy   (algo_busy),
    .algo_abort  (algo_abort),
    .cmd_to_read (cmd_to_read),
    .cmd_accept  (cmd_accept),
    .dout_en     (dout_en),
    .ready_busy  (ready_busy)
);

// File: tb/flash_rst_seq_tb.sv
`timescale 1ns/1ps
module flash_rst_seq_tb;
    localparam int MIN_PULSE = 4;
    localparam int T_BUSY    = 24;
    localparam int T_IDLE    = 8;
    localparam int T_HOLD    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin_n = 1'b1;
    logic oe_n = 1'b0;
    logic ce_n = 1'b0;
    logic algo_busy = 1'b0;
    logic algo_abort, cmd_to_read, cmd_accept, dout_en, ready_busy;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_rst_seq #(
        .MIN_PULSE (MIN_PULSE),
        .T_BUSY    (T_BUSY),
        .T_IDLE    (T_IDLE),
        .T_HOLD    (T_HOLD)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_pin_n   (rst_pin_n),
        .oe_n        (oe_n),
        .ce_n        (ce_n),
        .algo_busy   (algo_busy),
        .algo_abort  (algo_abort),
        .cmd_to_read (cmd_to_read),
        .cmd_accept  (cmd_accept),
        .dout_en     (dout_en),
        .ready_busy  (ready_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Negedge index (counted from the negedge the pin is driven low) at
    // which commands resume, for a single low pulse sampled on L edges.
    function automatic int exp_open(input int L, input bit busy);
        if (L < MIN_PULSE) return L + 1;
        if (busy) return imax(MIN_PULSE + T_BUSY, L + 1);
        return imax(MIN_PULSE + T_IDLE, L + 1) + T_HOLD;
    endfunction

    // Drive up to two low pulses and check the outcome at the ports.
    task automatic episode(input string req, input int la, input int b0, input int lb,
                           input bit busy, input int open_m, input int ready_m,
                           input int exp_abort, input int exp_clr);
        int n_abort = 0;
        int n_clr = 0;
        int n_rlow = 0;
        int n_rbad = 0;
        int n_gate = 0;
        int last = imax(open_m, ready_m) + 2;
        algo_busy = busy;
        for (int m = 0; m <= last; m++) begin
            @(negedge clk);
            if (algo_abort) begin
                n_abort++;
                algo_busy = 1'b0;
            end
            if (cmd_to_read) n_clr++;
            if (!ready_busy) n_rlow++;
            if (ready_m > 0 && m >= MIN_PULSE && m < ready_m && ready_busy) n_rbad++;
            if (!rst_pin_n && (cmd_accept || dout_en)) n_gate++;
            if (m == open_m - 1) check({req, " blocked before resume"}, int'(cmd_accept), 0);
            if (m == open_m) begin
                check({req, " commands resume"}, int'(cmd_accept), 1);
                check({req, " R9 drivers resume"}, int'(dout_en), 1);
            end
            if (ready_m > 0 && m == ready_m) check({req, " ready returns"}, int'(ready_busy), 1);
            rst_pin_n = !((m < la) || (lb > 0 && m >= b0 && m < b0 + lb));
        end
        rst_pin_n = 1'b1;
        check({req, " abort pulses (R2)"}, n_abort, exp_abort);
        check({req, " clear pulses (R3)"}, n_clr, exp_clr);
        check({req, " R4 gated while pin low"}, n_gate, 0);
        if (ready_m > 0) check({req, " R5 busy held"}, n_rbad, 0);
        if (!busy) check({req, " R6 ready never low"}, n_rlow, 0);
        algo_busy = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 cmd_accept", int'(cmd_accept), 1);
        check("R10 ready_busy", int'(ready_busy), 1);
        check("R10 abort", int'(algo_abort), 0);
        check("R10 clear", int'(cmd_to_read), 0);
        check("R10 dout_en", int'(dout_en), 1);
        // R11 ready follows engine outside reset handling
        algo_busy = 1'b1;
        @(negedge clk) check("R11 ready low while engine busy", int'(ready_busy), 0);
        algo_busy = 1'b0;
        @(negedge clk) check("R11 ready high while engine idle", int'(ready_busy), 1);
        // R9 output-enable and chip-enable gating
        oe_n = 1'b1;
        @(negedge clk) check("R9 oe_n high disables drivers", int'(dout_en), 0);
        check("R9 oe_n leaves commands", int'(cmd_accept), 1);
        oe_n = 1'b0; ce_n = 1'b1;
        @(negedge clk) check("R9 ce_n high disables drivers", int'(dout_en), 0);
        ce_n = 1'b0;
        @(negedge clk);

        // R1: one cycle short of qualification, engine busy
        episode("R1 filtered", MIN_PULSE - 1, 0, 0, 1'b1, MIN_PULSE, 0, 0, 0);
        // R5: busy path, short hold
        episode("R5 busy short", MIN_PULSE + 6, 0, 0, 1'b1,
                MIN_PULSE + T_BUSY, MIN_PULSE + T_BUSY, 1, 1);
        // R5: busy path, hold longer than the interval
        episode("R5 busy long", MIN_PULSE + T_BUSY + 3, 0, 0, 1'b1,
                MIN_PULSE + T_BUSY + 4, MIN_PULSE + T_BUSY, 1, 1);
        // R6: idle path, released after the short interval
        episode("R6 idle long", MIN_PULSE + T_IDLE + 3, 0, 0, 1'b0,
                MIN_PULSE + T_IDLE + 4 + T_HOLD, 0, 0, 1);
        // R7: idle path, released early
        episode("R7 idle short", MIN_PULSE + 2, 0, 0, 1'b0,
                MIN_PULSE + T_IDLE + T_HOLD, 0, 0, 1);
        // R8: re-qualified reset during busy recovery restarts the interval
        episode("R8 requalify", MIN_PULSE + 2, MIN_PULSE + 6, MIN_PULSE + 1, 1'b1,
                2 * MIN_PULSE + 6 + T_BUSY, 2 * MIN_PULSE + 6 + T_BUSY, 1, 2);
        // R8: glitch during read hold-off
        episode("R8 holdoff glitch", MIN_PULSE + T_IDLE + 2, MIN_PULSE + T_IDLE + 4, 2, 1'b0,
                MIN_PULSE + T_IDLE + 3 + T_HOLD, 0, 0, 1);

        // constrained random pulse lengths and engine states
        for (int it = 0; it < 40; it++) begin
            int L = 1 + int'($urandom % (MIN_PULSE + T_BUSY + 4));
            bit b = 1'($urandom % 2);
            bit q = (L >= MIN_PULSE);
            episode(q ? (b ? "R5 random" : "R6 random") : "R1 random", L, 0, 0, b,
                    exp_open(L, b), (b && q) ? MIN_PULSE + T_BUSY : 0,
                    (b && q) ? 1 : 0, q ? 1 : 0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule